// File: doc/BRIEF.md
# Nested Priority Event Controller

This block decides which event a processor core services next. Five event classes feed it. In priority order from highest to lowest they are debug emulation, reset request, non-maskable interrupt, exception and general interrupt. Each request is latched as pending. The block grants the highest-priority pending class only when that class outranks every handler already in progress. A higher-priority event can therefore preempt a running handler, and an event of equal or lower priority waits. When it grants an event, the block pulses a take strobe with a class code, marks the class active, and stores the program counter supplied at that moment in a return register that belongs to that class.

A return-from-event input retires the highest-priority active handler. The block then presents the return address saved for that class. General interrupts can be held off with a global enable. The other four classes cannot be masked. Non-maskable interrupts come either from an external pin or from a watchdog expiry. Exceptions arrive synchronously with the instruction that faulted, and interrupts arrive asynchronously. Both enter through the same pending latch.

Top module: `cec_core`

## Requirements
- R1: After reset, take_evt and ret_valid are 0, take_cls and ret_pc are 0, and active_o is 0.
- R2: A request sampled at one clock edge gives take_evt = 1 for exactly one cycle after the following edge, provided nothing blocks it. take_cls then carries the class code: emulation 0, reset 1, NMI 2, exception 3, interrupt 4. Bit k of active_o becomes 1 for class code k.
- R3: When several classes are pending at once, the class with the lowest code is taken first. The others stay pending.
- R4: An NMI is raised by nmi_pin or by wdog_expire, and either one alone is sufficient.
- R5: A pending class is taken only if its code is strictly lower than that of every active class. An equal or lower-priority request stays pending until the blocking handlers retire.
- R6: On a take, cur_pc is saved in the return register of the class being taken. A later return from that class presents that value on ret_pc.
- R7: rte, sampled at an edge while some class is active, clears the active bit with the lowest code. It also sets ret_valid = 1 for one cycle, with ret_pc equal to that class's saved address.
- R8: rte while no class is active is ignored. ret_valid stays 0 and active_o stays 0.
- R9: While irq_en = 0, a pending interrupt (code 4) is not taken but stays pending, and it is taken once irq_en returns to 1. Classes 0 to 3 are not affected by irq_en.
- R10: If a take and a return fall on the same edge, both happen. The new event is judged against the active set as it stood before the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_req | input | 1 | Emulation event request |
| rst_req | input | 1 | Reset event request |
| nmi_pin | input | 1 | External non-maskable interrupt request |
| wdog_expire | input | 1 | Watchdog expiry, raises an NMI |
| exc_req | input | 1 | Synchronous exception request |
| irq_req | input | 1 | General interrupt request |
| irq_en | input | 1 | Global enable for general interrupts |
| rte | input | 1 | Return from the current event |
| cur_pc | input | AW | Program counter, saved when an event is taken |
| take_evt | output | 1 | One-cycle strobe: an event is taken |
| take_cls | output | 3 | Code of the class taken |
| ret_valid | output | 1 | One-cycle strobe: a handler retired |
| ret_pc | output | AW | Return address of the class that retired |
| active_o | output | 5 | Handlers in progress, one bit per class code |

## Verification
A take and a return can land on the same clock edge. The bench sets this up by starting an interrupt handler, latching an NMI, and asserting rte in the cycle in which the NMI is decided. It then expects the NMI strobe and the interrupt's return strobe together. ret_pc must equal the interrupt's saved address, and active_o must hold only the NMI bit afterwards. The exhaustive sweep over all 31 request combinations also places each return one cycle before the next decision. This confirms that a return alone never lets a lower class through on the same edge.

// File: rtl/cec_pkg.sv
package cec_pkg;
  localparam int NCLS = 5;
  localparam int CW   = 3;

  typedef enum logic [CW-1:0] {
    EV_EMU = 3'd0,
    EV_RST = 3'd1,
    EV_NMI = 3'd2,
    EV_EXC = 3'd3,
    EV_IRQ = 3'd4
  } ev_cls_e;

  // lowest set index of a class mask, NCLS when empty
  function automatic logic [CW-1:0] first_set(input logic [NCLS-1:0] m);
    logic [CW-1:0] r;
    r = CW'(NCLS);
    for (int i = NCLS - 1; i >= 0; i--) begin
      if (m[i]) r = CW'(i);
    end
    return r;
  endfunction

  function automatic logic [NCLS-1:0] one_hot(input logic [CW-1:0] c);
    logic [NCLS-1:0] r;
    r = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (c == CW'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/cec_pend.sv
module cec_pend
  import cec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] req,
  input  logic [NCLS-1:0] clr,
  output logic [NCLS-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | req;
  end
endmodule

// File: rtl/cec_arb.sv
module cec_arb
  import cec_pkg::*;
(
  input  logic [NCLS-1:0] pend,
  input  logic [NCLS-1:0] act,
  input  logic            irq_en,
  output logic            go,
  output logic [CW-1:0]   win
);
  logic [NCLS-1:0] mask;
  logic [NCLS-1:0] elig;
  logic [CW-1:0]   top_act;

  always_comb begin
    mask          = '1;
    mask[EV_IRQ]  = irq_en;
    elig          = pend & mask;
    win           = first_set(elig);
    top_act       = first_set(act);
    go            = (elig != '0) && (win < top_act);
  end
endmodule

// File: rtl/cec_ctx.sv
module cec_ctx
  import cec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [CW-1:0]   win,
  input  logic [AW-1:0]   cur_pc,
  input  logic            rte,
  output logic [NCLS-1:0] act,
  output logic            ret_valid,
  output logic [AW-1:0]   ret_pc
);
  logic [AW-1:0]   ret_q [NCLS];
  logic [CW-1:0]   top_act;
  logic            retire;
  logic [NCLS-1:0] act_n;

  always_comb begin
    top_act = first_set(act);
    retire  = rte && (act != '0);
    act_n   = act;
    if (retire) act_n = act_n & ~one_hot(top_act);
    if (go)     act_n = act_n | one_hot(win);
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_ret
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ret_q[g] <= '0;
      else if (go && win == CW'(g))    ret_q[g] <= cur_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
    end else begin
      act       <= act_n;
      ret_valid <= retire;
      if (retire) ret_pc <= ret_q[top_act];
    end
  end
endmodule

// File: rtl/cec_core.sv
module cec_core
  import cec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_req,
  input  logic          rst_req,
  input  logic          nmi_pin,
  input  logic          wdog_expire,
  input  logic          exc_req,
  input  logic          irq_req,
  input  logic          irq_en,
  input  logic          rte,
  input  logic [AW-1:0] cur_pc,
  output logic          take_evt,
  output logic [2:0]    take_cls,
  output logic          ret_valid,
  output logic [AW-1:0] ret_pc,
  output logic [4:0]    active_o
);
  logic [NCLS-1:0] req_vec;
  logic [NCLS-1:0] pend;
  logic [NCLS-1:0] act;
  logic [NCLS-1:0] clr;
  logic            go;
  logic [CW-1:0]   win;

  assign req_vec = {irq_req, exc_req, nmi_pin | wdog_expire, rst_req, emu_req};
  assign clr     = go ? one_hot(win) : '0;

  cec_pend u_pend (.clk(clk), .rst_n(rst_n), .req(req_vec), .clr(clr), .pend(pend));

  cec_arb u_arb (.pend(pend), .act(act), .irq_en(irq_en), .go(go), .win(win));

  cec_ctx #(.AW(AW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .go(go), .win(win), .cur_pc(cur_pc), .rte(rte),
    .act(act), .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_evt <= 1'b0;
      take_cls <= '0;
    end else begin
      take_evt <= go;
      if (go) take_cls <= win;
    end
  end

  assign active_o = act;
endmodule

// File: rtl/cec_chk.sv
module cec_chk
  import cec_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       irq_en,
  input logic       rte,
  input logic       take_evt,
  input logic [2:0] take_cls,
  input logic       ret_valid,
  input logic [4:0] active_o
);
  // R2: a take names a real class and marks it active
  assert_take_marks_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (take_cls < 3'd5) && active_o[take_cls]);

  // R5: the class taken outranks everything active before the decision
  assert_take_above_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (first_set($past(active_o)) > take_cls));

  // R9: an interrupt is granted only while enabled
  assert_masked_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && take_cls == 3'd4) |-> $past(irq_en));

  // R7: a return strobe needs a prior rte with something active
  assert_ret_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ($past(rte) && $past(active_o) != 5'd0));

  // R8: rte while idle gives no return strobe
  assert_idle_rte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rte && active_o == 5'd0) |=> !ret_valid);
endmodule

bind cec_core cec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rte(rte), .take_evt(take_evt),
  .take_cls(take_cls), .ret_valid(ret_valid), .active_o(active_o)
);

// File: tb/sim_cec_core.sv
`timescale 1ns/100ps
module sim_cec_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        emu_req = 0, rst_req = 0, nmi_pin = 0, wdog_expire = 0, exc_req = 0, irq_req = 0;
  logic        irq_en = 1'b1;
  logic        rte = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        take_evt, ret_valid;
  logic [2:0]  take_cls;
  logic [31:0] ret_pc;
  logic [4:0]  active_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cec_core u0 (
    .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .rst_req(rst_req), .nmi_pin(nmi_pin),
    .wdog_expire(wdog_expire), .exc_req(exc_req), .irq_req(irq_req), .irq_en(irq_en),
    .rte(rte), .cur_pc(cur_pc), .take_evt(take_evt), .take_cls(take_cls),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .active_o(active_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive_req(input logic [4:0] m, input bit use_wd);
    emu_req     = m[0];
    rst_req     = m[1];
    nmi_pin     = m[2] & !use_wd;
    wdog_expire = m[2] & use_wd;
    exc_req     = m[3];
    irq_req     = m[4];
  endtask

  function automatic int low_bit(input logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return 5;
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [4:0]  rem;
    logic [31:0] pc;
    int          w;
    logic [31:0] pc_irq, pc_nmi;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 take_evt", 32'(take_evt), 0);
    chk("R1 ret_valid", 32'(ret_valid), 0);
    chk("R1 active_o", 32'(active_o), 0);
    chk("R1 ret_pc", ret_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: rte while idle
    rte = 1'b1;
    @(negedge clk);
    rte = 1'b0;
    chk("R8 ret_valid idle", 32'(ret_valid), 0);
    chk("R8 active_o idle", 32'(active_o), 0);
    @(negedge clk);

    // R2 R3 R4 R6 R7: all request combinations, drained in priority order
    for (int m = 1; m < 32; m++) begin
      rem = 5'(m);
      pc  = 32'h1000 + 32'(m) * 16;
      cur_pc = pc;
      drive_req(5'(m), m[0]);
      @(negedge clk);
      drive_req(5'd0, 1'b0);
      @(negedge clk);
      while (rem != 5'd0) begin
        w = low_bit(rem);
        chk("R2 R3 R4 take_evt", 32'(take_evt), 1);
        chk("R3 take_cls", 32'(take_cls), 32'(w));
        chk("R2 active_o", 32'(active_o), 32'(1 << w));
        rem = rem & ~5'(1 << w);
        rte = 1'b1;
        @(negedge clk);
        rte = 1'b0;
        chk("R7 ret_valid", 32'(ret_valid), 1);
        chk("R6 ret_pc", ret_pc, pc);
        chk("R7 active_o cleared", 32'(active_o), 0);
        chk("R5 no take with active", 32'(take_evt), 0);
        pc = pc + 1;
        cur_pc = pc;
        @(negedge clk);
      end
      chk("R2 single take", 32'(take_evt), 0);
      @(negedge clk);
    end

    // R5 R6: nesting NMI over interrupt, equal interrupt waits
    pc_irq = 32'hA000; pc_nmi = 32'hB000;
    cur_pc = pc_irq;
    irq_req = 1; @(negedge clk); irq_req = 0; @(negedge clk);
    chk("R5 irq taken", 32'(take_cls), 4);
    cur_pc = pc_nmi;
    nmi_pin = 1; @(negedge clk); nmi_pin = 0; @(negedge clk);
    chk("R5 nmi preempts", 32'(take_evt), 1);
    chk("R5 nmi cls", 32'(take_cls), 2);
    chk("R5 nested active", 32'(active_o), 32'h14);
    cur_pc = 32'hC000;
    irq_req = 1; @(negedge clk); irq_req = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R5 equal irq blocked", 32'(take_evt), 0);
    end
    rte = 1; @(negedge clk); rte = 0;
    chk("R7 retire nmi first", ret_pc, pc_nmi);
    chk("R7 irq still active", 32'(active_o), 32'h10);
    @(negedge clk);
    chk("R5 irq still blocked", 32'(take_evt), 0);
    rte = 1; @(negedge clk); rte = 0;
    chk("R6 irq ret_pc", ret_pc, pc_irq);
    @(negedge clk);
    chk("R5 waiting irq taken", 32'(take_evt), 1);
    chk("R5 waiting irq cls", 32'(take_cls), 4);
    rte = 1; @(negedge clk); rte = 0;
    chk("R6 second irq ret_pc", ret_pc, 32'hC000);
    @(negedge clk);

    // R9: mask holds interrupts, NMI unaffected
    irq_en = 0;
    irq_req = 1; @(negedge clk); irq_req = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 masked irq", 32'(take_evt), 0);
    end
    wdog_expire = 1; @(negedge clk); wdog_expire = 0; @(negedge clk);
    chk("R9 nmi while masked", 32'(take_evt), 1);
    chk("R4 R9 watchdog nmi cls", 32'(take_cls), 2);
    rte = 1; @(negedge clk); rte = 0; @(negedge clk);
    chk("R9 still masked", 32'(take_evt), 0);
    irq_en = 1; @(negedge clk);
    chk("R9 unmasked take", 32'(take_evt), 1);
    chk("R9 unmasked cls", 32'(take_cls), 4);
    rte = 1; @(negedge clk); rte = 0; @(negedge clk);

    // R10: take and return on the same edge
    cur_pc = 32'hD000;
    irq_req = 1; @(negedge clk); irq_req = 0; @(negedge clk);
    chk("R10 setup irq", 32'(active_o), 32'h10);
    cur_pc = 32'hE000;
    nmi_pin = 1; @(negedge clk); nmi_pin = 0;
    rte = 1; @(negedge clk); rte = 0;
    chk("R10 take", 32'(take_evt), 1);
    chk("R10 take cls", 32'(take_cls), 2);
    chk("R10 ret_valid", 32'(ret_valid), 1);
    chk("R10 ret_pc", ret_pc, 32'hD000);
    chk("R10 active", 32'(active_o), 32'h04);
    rte = 1; @(negedge clk); rte = 0;
    chk("R10 nmi ret_pc", ret_pc, 32'hE000);
    chk("R10 idle", 32'(active_o), 0);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule